// File: doc/BRIEF.md
# Saturating Doubling Multiply Lane Unit

This block multiplies two packed vectors of signed fixed-point lanes and offers two result families. The fractional high-half form doubles each lane product, adds a rounding bias of half a result unit, and keeps the upper half. This is the usual Q15/Q31 multiply with round-to-nearest. The widening form doubles the lane product into a lane of twice the width. It can return that doubled product as it is, add it to an accumulator lane, or subtract it from an accumulator lane. In both families the one case where doubling overflows, with both operands at the most negative code, is forced to the largest positive result.

Lanes are 16 or 32 bits wide and are chosen per operation. The widening forms take their source lanes from either the lower or the upper half of the operand vectors. Results come out a fixed number of cycles after a valid strobe, and a new operation may be issued every cycle. Any saturation in any lane sets a sticky flag, which holds until a separate clear input is pulsed.

Top module: `sdm_lane_unit`

## Requirements
- R1: With `op_i`=0 (fractional high half), each lane k of the result is ((2·a_k·b_k + 2^(W−1)) >> W) as an arithmetic shift. W is 16 when `lane_wide_i`=0 (four lanes at bits 16k) and 32 when `lane_wide_i`=1 (two lanes at bits 32k).
- R2: In the high-half form, a lane whose two operands both equal −2^(W−1) yields 2^(W−1)−1, and the operation counts as saturated.
- R3: With `op_i`=1 (widening), result lane j, of width 2W at bits 2W·j, is 2·a·b taken from source lane j when `upper_i`=0 and from source lane j+N/2 when `upper_i`=1, where N=64/W.
- R4: In the widening forms, a selected source pair with both operands at −2^(W−1) gives the product 2^(2W−1)−1 and counts as saturated.
- R5: With `op_i`=2 the result lane is acc+product, and with `op_i`=3 it is acc−product. The accumulator lane is 2W bits at bits 2W·j. The sum or difference is clamped to the 2W-bit signed range, and a clamp counts as saturated.
- R6: `out_valid_o` equals `in_valid_i` delayed by LATENCY cycles (default 2). Back-to-back operations come out in issue order, and `out_res_o` changes only in a cycle in which `out_valid_o` is high.
- R7: `sat_flag_o` rises in the cycle a saturated result appears on the output and stays high until `clr_sat_i` is sampled high. A saturated result that appears in the same cycle as the clear leaves the flag set.
- R8: After reset, `out_valid_o`, `sat_flag_o` and `out_res_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid_i | input | 1 | Operation issue strobe |
| op_i | input | 2 | 0 high half, 1 widening, 2 widening accumulate, 3 widening subtract |
| lane_wide_i | input | 1 | 0: 16-bit source lanes, 1: 32-bit source lanes |
| upper_i | input | 1 | Widening forms: take source lanes from the upper half |
| src_a_i | input | VEC_W | First operand vector |
| src_b_i | input | VEC_W | Second operand vector |
| src_acc_i | input | VEC_W | Accumulator vector of double-width lanes |
| clr_sat_i | input | 1 | Clears the sticky saturation flag |
| out_valid_o | output | 1 | Result strobe |
| out_res_o | output | VEC_W | Result vector |
| sat_flag_o | output | 1 | Sticky saturation flag |

## Verification
The assertions check the timing rules on every cycle: the valid strobe arrives after exactly LATENCY cycles, the result holds between strobes, the flag stays set until cleared, drops after a clear with no new saturating result, and rises only together with a result. The arithmetic can only be shown by the bench's scenarios. These include sweeps of edge operand values over both lane sizes and all four operations, the upper and lower half selection, accumulator clamping at both ends of the range, the rounding bias, and a clear that coincides with a saturating result.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  typedef enum logic [1:0] {
    OP_RDMULH = 2'd0,
    OP_MULL   = 2'd1,
    OP_MLAL   = 2'd2,
    OP_MLSL   = 2'd3
  } sdm_op_e;
endpackage

// File: rtl/sdm_prod.sv
// One signed lane: doubled full product and rounded high half, with the
// single overflowing operand pair forced to the positive limit.
module sdm_prod #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] dbl_o,
  output logic [W-1:0]   hi_o,
  output logic           sat_o
);
  localparam int DW = 2 * W;
  localparam logic [W-1:0]  MIN_W = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0]  MAX_W = {1'b0, {(W-1){1'b1}}};
  localparam logic [DW-1:0] MAX_D = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] RND   = {{W{1'b0}}, 1'b1, {(W-1){1'b0}}};

  logic signed [DW-1:0] prod;
  logic [DW-1:0]        twice;
  logic [DW-1:0]        rnd_sum;
  logic                 both_min;

  always_comb begin
    prod     = $signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{b_i[W-1]}}, b_i});
    twice    = {prod[DW-2:0], 1'b0};
    rnd_sum  = twice + RND;
    both_min = (a_i == MIN_W) && (b_i == MIN_W);
    sat_o    = both_min;
    dbl_o    = both_min ? MAX_D : twice;
    hi_o     = both_min ? MAX_W : rnd_sum[DW-1:W];
  end
endmodule

// File: rtl/sdm_accum.sv
// Double-width lane: pass, saturating add or saturating subtract.
module sdm_accum
  import sdm_pkg::*;
#(
  parameter int DW = 32
) (
  input  sdm_op_e         op_i,
  input  logic [DW-1:0]   prod_i,
  input  logic [DW-1:0]   acc_i,
  output logic [DW-1:0]   res_o,
  output logic            sat_o
);
  localparam logic [DW-1:0] MIN_D = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MAX_D = {1'b0, {(DW-1){1'b1}}};

  logic [DW-1:0] sum, dif, clamp;
  logic          add_ovf, sub_ovf;

  always_comb begin
    sum     = acc_i + prod_i;
    dif     = acc_i - prod_i;
    add_ovf = (acc_i[DW-1] == prod_i[DW-1]) && (sum[DW-1] != acc_i[DW-1]);
    sub_ovf = (acc_i[DW-1] != prod_i[DW-1]) && (dif[DW-1] != acc_i[DW-1]);
    clamp   = acc_i[DW-1] ? MIN_D : MAX_D;
    case (op_i)
      OP_MLAL: begin
        res_o = add_ovf ? clamp : sum;
        sat_o = add_ovf;
      end
      OP_MLSL: begin
        res_o = sub_ovf ? clamp : dif;
        sat_o = sub_ovf;
      end
      default: begin
        res_o = prod_i;
        sat_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sdm_width_path.sv
// All lanes of one source width, both result families.
module sdm_width_path
  import sdm_pkg::*;
#(
  parameter int VEC_W = 64,
  parameter int W     = 16
) (
  input  sdm_op_e          op_i,
  input  logic             upper_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic [VEC_W-1:0] acc_i,
  output logic [VEC_W-1:0] res_o,
  output logic             sat_o
);
  localparam int N  = VEC_W / W;
  localparam int NL = N / 2;
  localparam int DW = 2 * W;

  logic [DW-1:0]    dbl_l [N];
  logic [N-1:0]     psat;
  logic [NL-1:0]    lsat;
  logic [VEC_W-1:0] hi_vec;
  logic [VEC_W-1:0] long_vec;

  for (genvar gi = 0; gi < N; gi++) begin : g_prod
    sdm_prod #(.W(W)) u_prod (
      .a_i   (a_i[gi*W +: W]),
      .b_i   (b_i[gi*W +: W]),
      .dbl_o (dbl_l[gi]),
      .hi_o  (hi_vec[gi*W +: W]),
      .sat_o (psat[gi])
    );
  end

  for (genvar gj = 0; gj < NL; gj++) begin : g_long
    logic [DW-1:0] pick;
    logic          pick_sat;
    logic          acc_sat;
    assign pick     = upper_i ? dbl_l[gj+NL] : dbl_l[gj];
    assign pick_sat = upper_i ? psat[gj+NL]  : psat[gj];
    sdm_accum #(.DW(DW)) u_acc (
      .op_i   (op_i),
      .prod_i (pick),
      .acc_i  (acc_i[gj*DW +: DW]),
      .res_o  (long_vec[gj*DW +: DW]),
      .sat_o  (acc_sat)
    );
    assign lsat[gj] = pick_sat | acc_sat;
  end

  always_comb begin
    if (op_i == OP_RDMULH) begin
      res_o = hi_vec;
      sat_o = |psat;
    end else begin
      res_o = long_vec;
      sat_o = |lsat;
    end
  end
endmodule

// File: rtl/sdm_lane_unit.sv
module sdm_lane_unit
  import sdm_pkg::*;
#(
  parameter int VEC_W   = 64,
  parameter int LANE_W  = 16,
  parameter int LATENCY = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [1:0]       op_i,
  input  logic             lane_wide_i,
  input  logic             upper_i,
  input  logic [VEC_W-1:0] src_a_i,
  input  logic [VEC_W-1:0] src_b_i,
  input  logic [VEC_W-1:0] src_acc_i,
  input  logic             clr_sat_i,
  output logic             out_valid_o,
  output logic [VEC_W-1:0] out_res_o,
  output logic             sat_flag_o
);
  localparam int WIDE_W = 2 * LANE_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sdm_op_e          op_e;
  logic [VEC_W-1:0] nar_res, wid_res, comb_res;
  logic             nar_sat, wid_sat, comb_sat;

  assign op_e = sdm_op_e'(op_i);

  sdm_width_path #(.VEC_W(VEC_W), .W(LANE_W)) u_narrow (
    .op_i(op_e), .upper_i(upper_i), .a_i(src_a_i), .b_i(src_b_i),
    .acc_i(src_acc_i), .res_o(nar_res), .sat_o(nar_sat)
  );

  sdm_width_path #(.VEC_W(VEC_W), .W(WIDE_W)) u_wide (
    .op_i(op_e), .upper_i(upper_i), .a_i(src_a_i), .b_i(src_b_i),
    .acc_i(src_acc_i), .res_o(wid_res), .sat_o(wid_sat)
  );

  assign comb_res = lane_wide_i ? wid_res : nar_res;
  assign comb_sat = lane_wide_i ? wid_sat : nar_sat;

  // result pipeline
  logic [VEC_W-1:0]   res_d [LATENCY];
  logic [VEC_W-1:0]   res_q [LATENCY];
  logic [LATENCY-1:0] vld_d, vld_q, sat_d, sat_q;
  logic               flag_d, flag_q;

  always_comb begin
    vld_d[0] = in_valid_i;
    sat_d[0] = comb_sat;
    res_d[0] = comb_res;
    for (int k = 1; k < LATENCY; k++) begin
      vld_d[k] = vld_q[k-1];
      sat_d[k] = sat_q[k-1];
      res_d[k] = res_q[k-1];
    end
    // a saturating result arriving with a clear keeps the flag set
    flag_d = (flag_q & ~clr_sat_i) | (vld_d[LATENCY-1] & sat_d[LATENCY-1]);
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q  <= '0;
      sat_q  <= '0;
      flag_q <= 1'b0;
      for (int k = 0; k < LATENCY; k++) res_q[k] <= '0;
    end else begin
      vld_q  <= vld_d;
      flag_q <= flag_d;
      for (int k = 0; k < LATENCY; k++) begin
        if (vld_d[k]) begin
          res_q[k] <= res_d[k];
          sat_q[k] <= sat_d[k];
        end
      end
    end
  end

  assign out_valid_o = vld_q[LATENCY-1];
  assign out_res_o   = res_q[LATENCY-1];
  assign sat_flag_o  = flag_q;
endmodule

// File: rtl/sdm_lane_unit_chk.sv
module sdm_lane_unit_chk #(
  parameter int VEC_W   = 64,
  parameter int LATENCY = 2
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             in_valid_i,
  input logic             clr_sat_i,
  input logic             out_valid_o,
  input logic [VEC_W-1:0] out_res_o,
  input logic             sat_flag_o
);
  logic [LATENCY-1:0] issue_hist;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) issue_hist <= '0;
    else begin
      issue_hist[0] <= in_valid_i;
      for (int k = 1; k < LATENCY; k++) issue_hist[k] <= issue_hist[k-1];
    end
  end

  // R6
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    out_valid_o == issue_hist[LATENCY-1]);

  // R6
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !out_valid_o |-> $stable(out_res_o));

  // R7
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sat_flag_o && !clr_sat_i) |=> sat_flag_o);

  // R7
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    clr_sat_i |=> (!sat_flag_o || out_valid_o));

  // R7
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(sat_flag_o) |-> out_valid_o);
endmodule

bind sdm_lane_unit sdm_lane_unit_chk #(.VEC_W(VEC_W), .LATENCY(LATENCY)) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_int_n),
  .in_valid_i  (in_valid_i),
  .clr_sat_i   (clr_sat_i),
  .out_valid_o (out_valid_o),
  .out_res_o   (out_res_o),
  .sat_flag_o  (sat_flag_o)
);

// File: tb/test_sdm_lane_unit.sv
`timescale 1ns/1ps
module test_sdm_lane_unit;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, lane_wide, upper, clr_sat;
  logic [1:0]  op;
  logic [63:0] src_a, src_b, src_acc;
  logic        out_valid, sat_flag;
  logic [63:0] out_res;

  int total = 0;
  int bad   = 0;
  logic mflag = 1'b0;

  always #2.5 clk = ~clk;

  sdm_lane_unit #(.VEC_W(64), .LANE_W(16), .LATENCY(LAT)) i_sdm_lane_unit (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .op_i(op),
    .lane_wide_i(lane_wide), .upper_i(upper), .src_a_i(src_a),
    .src_b_i(src_b), .src_acc_i(src_acc), .clr_sat_i(clr_sat),
    .out_valid_o(out_valid), .out_res_o(out_res), .sat_flag_o(sat_flag)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic signed [129:0] sx(input logic [63:0] v, input int w);
    logic signed [129:0] t;
    for (int i = 0; i < 130; i++) t[i] = (i < w) ? v[i] : v[w-1];
    return t;
  endfunction

  function automatic logic [63:0] lane(input logic [63:0] v, input int w, input int k);
    logic [63:0] m;
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    return (v >> (k * w)) & m;
  endfunction

  // reference arithmetic, exact in 130 bits
  task automatic model(input logic [1:0] o, input logic l32, input logic up,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] acc,
                       output logic [63:0] er, output logic es);
    int w, n, dw, src;
    logic signed [129:0] sa, sb, r, lo, hi, one;
    logic [63:0] m;
    one = 130'sd1;
    w = l32 ? 32 : 16;
    n = 64 / w;
    dw = 2 * w;
    er = '0;
    es = 1'b0;
    if (o == 2'd0) begin
      m = (64'd1 << w) - 64'd1;
      for (int k = 0; k < n; k++) begin
        sa = sx(lane(a, w, k), w);
        sb = sx(lane(b, w, k), w);
        if (sa == -(one <<< (w-1)) && sb == -(one <<< (w-1))) begin
          r = (one <<< (w-1)) - 1;
          es = 1'b1;
        end else begin
          r = (2 * sa * sb + (one <<< (w-1))) >>> w;
        end
        er = er | ((r[63:0] & m) << (k * w));
      end
    end else begin
      m = (dw == 64) ? '1 : ((64'd1 << dw) - 64'd1);
      hi = (one <<< (dw-1)) - 1;
      lo = -(one <<< (dw-1));
      for (int k = 0; k < n / 2; k++) begin
        src = up ? k + n / 2 : k;
        sa = sx(lane(a, w, src), w);
        sb = sx(lane(b, w, src), w);
        if (sa == -(one <<< (w-1)) && sb == -(one <<< (w-1))) begin
          r = hi;
          es = 1'b1;
        end else begin
          r = 2 * sa * sb;
        end
        if (o == 2'd2) r = sx(lane(acc, dw, k), dw) + r;
        if (o == 2'd3) r = sx(lane(acc, dw, k), dw) - r;
        if (r > hi) begin r = hi; es = 1'b1; end
        if (r < lo) begin r = lo; es = 1'b1; end
        er = er | ((r[63:0] & m) << (k * dw));
      end
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic l32, input logic up,
                        input logic [63:0] a, input logic [63:0] b, input logic [63:0] acc,
                        input logic do_clr);
    logic [63:0] er;
    logic es;
    string rr, rf;
    model(o, l32, up, a, b, acc, er, es);
    rr = (o == 2'd0) ? "R1 result" : (o == 2'd1) ? "R3 result" : "R5 result";
    rf = (o == 2'd0) ? "R2 flag"   : (o == 2'd1) ? "R4 flag"   : "R5 flag";
    @(negedge clk);
    op = o; lane_wide = l32; upper = up;
    src_a = a; src_b = b; src_acc = acc;
    in_valid = 1'b1; clr_sat = do_clr;
    @(negedge clk);
    in_valid = 1'b0; clr_sat = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    mflag = (do_clr ? 1'b0 : mflag) | es;
    check("R6 valid", {63'd0, out_valid}, 64'd1);
    check(rr, out_res, er);
    check(rf, {63'd0, sat_flag}, {63'd0, mflag});
  endtask

  function automatic logic [63:0] e16(input int i);
    case (i % 10)
      0: return 64'h8000; 1: return 64'h8001; 2: return 64'hC000;
      3: return 64'hFFFF; 4: return 64'h0000; 5: return 64'h0001;
      6: return 64'h4000; 7: return 64'h7FFF; 8: return 64'h1234;
      default: return 64'hABCD;
    endcase
  endfunction

  function automatic logic [63:0] e32(input int i);
    case (i % 10)
      0: return 64'h8000_0000; 1: return 64'h8000_0001; 2: return 64'hC000_0000;
      3: return 64'hFFFF_FFFF; 4: return 64'h0000_0000; 5: return 64'h0000_0001;
      6: return 64'h4000_0000; 7: return 64'h7FFF_FFFF; 8: return 64'h1234_5678;
      default: return 64'hABCD_EF01;
    endcase
  endfunction

  function automatic logic [63:0] eacc(input int i, input int dw);
    logic [63:0] mx, m;
    m  = (dw == 64) ? '1 : ((64'd1 << dw) - 64'd1);
    mx = m >> 1;
    case (i % 8)
      0: return mx;
      1: return mx + 64'd1;
      2: return 64'd0;
      3: return m;
      4: return mx - 64'd5;
      5: return (mx + 64'd6) & m;
      6: return 64'h0123_4567_89AB_CDEF & m;
      default: return 64'd1;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] a, b, acc, er0, er1, er2, held;
    logic es0, es1, es2;
    rst_n = 1'b0; in_valid = 1'b0; op = 2'd0; lane_wide = 1'b0; upper = 1'b0;
    src_a = '0; src_b = '0; src_acc = '0; clr_sat = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 valid", {63'd0, out_valid}, 64'd0);
    check("R8 flag", {63'd0, sat_flag}, 64'd0);
    check("R8 result", out_res, 64'd0);

    // sweeps over edge operands, all ops and both lane sizes (R1..R5)
    for (int o = 0; o < 4; o++) begin
      for (int l = 0; l < 2; l++) begin
        for (int i = 0; i < 10; i++) begin
          for (int j = 0; j < 10; j++) begin
            a = '0; b = '0; acc = '0;
            if (l == 0) begin
              for (int k = 0; k < 4; k++) begin
                a = a | (e16(i + k) << (16 * k));
                b = b | (e16(j + 3 * k) << (16 * k));
              end
              for (int k = 0; k < 2; k++) acc = acc | (eacc(i + j + k, 32) << (32 * k));
            end else begin
              for (int k = 0; k < 2; k++) begin
                a = a | (e32(i + k) << (32 * k));
                b = b | (e32(j + 3 * k) << (32 * k));
              end
              acc = eacc(i + j, 64);
            end
            run_op(o[1:0], l[0], ((i + j) % 2) == 1, a, b, acc, 1'b1);
          end
        end
      end
    end

    // R1 rounding bias: 0x4000*0x0001 -> 2^15 + 2^15 -> 1
    run_op(2'd0, 1'b0, 1'b0, 64'h4000, 64'h0001, 64'd0, 1'b1);
    check("R1 round up", out_res & 64'hFFFF, 64'h0001);
    // R3 upper half selection: only upper lanes nonzero
    run_op(2'd1, 1'b0, 1'b1, 64'h0003_0002_0000_0000, 64'h0005_0007_0000_0000, 64'd0, 1'b1);
    check("R3 upper half", out_res, {32'd30, 32'd28});
    // R4 widening min*min at 32 bits
    run_op(2'd1, 1'b1, 1'b0, 64'h8000_0000, 64'h8000_0000, 64'd0, 1'b1);
    check("R4 limit", out_res, 64'h7FFF_FFFF_FFFF_FFFF);
    // R5 subtract clamps low
    run_op(2'd3, 1'b0, 1'b0, 64'h0000_7FFF, 64'h0000_7FFF, 64'h0000_0000_8000_0000, 1'b1);
    check("R5 clamp low", out_res & 64'hFFFF_FFFF, 64'h8000_0000);

    // R7 sticky flag across a clean result
    run_op(2'd0, 1'b0, 1'b0, 64'h8000, 64'h8000, 64'd0, 1'b1);
    run_op(2'd0, 1'b0, 1'b0, 64'h0002, 64'h0003, 64'd0, 1'b0);
    check("R7 sticky", {63'd0, sat_flag}, 64'd1);
    held = out_res;
    @(negedge clk); clr_sat = 1'b1;
    @(negedge clk); clr_sat = 1'b0;
    check("R7 cleared", {63'd0, sat_flag}, 64'd0);
    check("R6 no valid", {63'd0, out_valid}, 64'd0);
    check("R6 held", out_res, held);
    mflag = 1'b0;
    // R7 clear coinciding with saturated arrival
    @(negedge clk);
    op = 2'd0; lane_wide = 1'b1; upper = 1'b0;
    src_a = 64'h8000_0000; src_b = 64'h8000_0000; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0; clr_sat = 1'b1;
    @(negedge clk); clr_sat = 1'b0;
    check("R7 set wins", {63'd0, sat_flag}, 64'd1);
    check("R2 wide limit", out_res & 64'hFFFF_FFFF, 64'h7FFF_FFFF);

    // R6 back-to-back issue, results in order
    model(2'd0, 1'b0, 1'b0, 64'h1111_2222_3333_4444, 64'h7FFF_7FFF_7FFF_7FFF, 64'd0, er0, es0);
    model(2'd1, 1'b0, 1'b0, 64'h0000_0000_0005_FFFD, 64'h0000_0000_0003_0004, 64'd0, er1, es1);
    model(2'd2, 1'b1, 1'b1, 64'h0000_0009_0000_0000, 64'hFFFF_FFFE_0000_0000, 64'd100, er2, es2);
    @(negedge clk);
    op = 2'd0; lane_wide = 1'b0; upper = 1'b0; in_valid = 1'b1;
    src_a = 64'h1111_2222_3333_4444; src_b = 64'h7FFF_7FFF_7FFF_7FFF; src_acc = 64'd0;
    @(negedge clk);
    op = 2'd1; src_a = 64'h0000_0000_0005_FFFD; src_b = 64'h0000_0000_0003_0004;
    @(negedge clk);
    check("R6 order 0", out_res, er0);
    op = 2'd2; lane_wide = 1'b1; upper = 1'b1;
    src_a = 64'h0000_0009_0000_0000; src_b = 64'hFFFF_FFFE_0000_0000; src_acc = 64'd100;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 order 1", out_res, er1);
    @(negedge clk);
    check("R6 order 2", out_res, er2);
    check("R6 valid run", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    check("R6 valid end", {63'd0, out_valid}, 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule